// File: doc/BRIEF.md
# Verified SPI Register-Read Slave

This block is an SPI slave that serves multi-byte reads from a register file and checks every step of the exchange. A read runs as a fixed series of bytes. The master sends a start address, and the slave returns it one byte later. The master then sends a protected byte count, and the slave streams the requested registers. The master loops each data byte back to the slave one byte after receiving it. In the byte that carries the last loop-back, the slave returns the start address a second time. The exchange ends with a control byte. The slave answers it with a pass pattern or a fail pattern.

The block samples SCK, NCS and SI with the system clock. It then sees each SCK edge a few system cycles after it occurs, so SCK must be much slower than the system clock. SO follows SPI mode 0 and sends the MSB first. The register file is outside the block and is read combinationally through an 8-bit address and an 8-bit data port. A master that does not need verification may raise NCS at any byte boundary.

Top module: `spiVerifiedRead`

## Requirements
- R1: Byte 0 returns 0x00 while the start address arrives. Byte 1 returns the start address, whatever the master sends in that byte.
- R2: Byte 2 carries the count: the upper nibble n and, in the lower nibble, the bitwise inverse of n. The slave returns 0x00 during byte 2 and sends n+1 data bytes (1 to 16).
- R3: Data byte k (k = 0 to n) is the register at start address + k, modulo 256. The register-file address steps by one per data byte.
- R4: The byte after the last data byte returns the start address. When every loop-back matched and the count was valid, the next byte returns 0x59 against a 0x59 control byte.
- R5: If any loop-back byte differs from the data byte sent one byte earlier, the control byte returns 0xA6.
- R6: If the lower count nibble is not the inverse of the upper nibble, every data byte is 0x00 and the control byte returns 0xA6.
- R7: During the control byte, each SI bit is compared with the SO bit being driven. From the first mismatch on, the remaining bits of that byte are taken from 0xA6 at the same bit positions.
- R8: While NCS is high, SO is 0 and no byte completes. Raising NCS at any byte boundary returns the block to its idle state, and the next read behaves as if the aborted one never happened.
- R9: SO changes only after an SCK falling edge, or when NCS changes. SI is taken on the SCK rising edge.
- R10: Bytes after the control byte return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the SPI pins |
| rstN | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | SPI serial clock, idle low |
| ncs | input | 1 | SPI chip select, active low |
| si | input | 1 | Serial data from master |
| so | output | 1 | Serial data to master, MSB first |
| regAddr | output | 8 | Register-file read address |
| regData | input | 8 | Register-file read data (combinational) |

## Verification
Every result on SO appears one full byte after the byte that caused it: the address echo, the data stream, the second address echo and the control-byte verdict. A new SO bit appears about four system cycles after each SCK falling edge, because of two synchroniser stages, an edge detector and the shift register. The bench therefore samples SO eight cycles after the falling edge, just before it raises SCK. It samples SO again just before the next fall, to confirm that the rising edge did not move it. The driver pushes the expected byte for every position of a read, including real-time control-byte switching and early aborts, and the monitor compares each byte once it has been assembled.

// File: rtl/spiVrdPkg.sv
package spiVrdPkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;

  typedef enum logic [2:0] {
    PH_ADDR, PH_ADDR_ECHO, PH_COUNT, PH_DATA, PH_TAIL, PH_CTRL, PH_DONE
  } phase_t;

  typedef enum logic [1:0] {TX_ZERO, TX_ADDR, TX_DATA, TX_CTRL} txSel_t;

  typedef struct packed {
    logic   capAddr;
    logic   setCntBad;
    logic   setEchoErr;
    logic   incPtr;
    txSel_t txSel;
    logic   ctrlPhase;
  } strobe_t;
endpackage

// File: rtl/spiVrdSync.sv
module spiVrdSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sckIn,
  input  logic ncsIn,
  input  logic siIn,
  output logic sckRise,
  output logic sckFall,
  output logic active,
  output logic siS
);
  logic [STAGES-1:0] sckSh, ncsSh, siSh;
  logic sckPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSh   <= '0;
      ncsSh   <= '1;
      siSh    <= '0;
      sckPrev <= 1'b0;
    end else begin
      sckSh   <= {sckSh[STAGES-2:0], sckIn};
      ncsSh   <= {ncsSh[STAGES-2:0], ncsIn};
      siSh    <= {siSh[STAGES-2:0], siIn};
      sckPrev <= sckSh[STAGES-1];
    end
  end

  assign sckRise = sckSh[STAGES-1] & ~sckPrev;
  assign sckFall = ~sckSh[STAGES-1] & sckPrev;
  assign active  = ~ncsSh[STAGES-1];
  assign siS     = siSh[STAGES-1];
endmodule

// File: rtl/spiVrdCtrl.sv
module spiVrdCtrl
  import spiVrdPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              active,
  input  logic              byteEnd,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              echoOk,
  output strobe_t           strb
);
  phase_t           phase, phaseNext;
  logic [CNT_W-1:0] remain;
  logic             firstData;

  always_comb begin
    strb           = '0;
    strb.txSel     = TX_ZERO;
    strb.ctrlPhase = (phase == PH_CTRL);
    phaseNext      = phase;
    case (phase)
      PH_ADDR: begin
        strb.capAddr = 1'b1;
        strb.txSel   = TX_ADDR;
        phaseNext    = PH_ADDR_ECHO;
      end
      PH_ADDR_ECHO: phaseNext = PH_COUNT;
      PH_COUNT: begin
        strb.setCntBad = (rxByte[CNT_W-1:0] != ~rxByte[BYTE_W-1:CNT_W]);
        strb.incPtr    = 1'b1;
        strb.txSel     = TX_DATA;
        phaseNext      = PH_DATA;
      end
      PH_DATA: begin
        strb.setEchoErr = !firstData && !echoOk;
        if (remain == '0) begin
          strb.txSel = TX_ADDR;
          phaseNext  = PH_TAIL;
        end else begin
          strb.txSel  = TX_DATA;
          strb.incPtr = 1'b1;
        end
      end
      PH_TAIL: begin
        strb.setEchoErr = !echoOk;
        strb.txSel      = TX_CTRL;
        phaseNext       = PH_CTRL;
      end
      PH_CTRL: phaseNext = PH_DONE;
      default: phaseNext = PH_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_ADDR;
      remain    <= '0;
      firstData <= 1'b1;
    end else if (!active) begin
      phase     <= PH_ADDR;
      remain    <= '0;
      firstData <= 1'b1;
    end else if (byteEnd) begin
      phase <= phaseNext;
      if (phase == PH_COUNT) begin
        remain    <= rxByte[BYTE_W-1:CNT_W];
        firstData <= 1'b1;
      end
      if (phase == PH_DATA) begin
        firstData <= 1'b0;
        if (remain != '0) remain <= remain - 1'b1;
      end
    end
  end
endmodule

// File: rtl/spiVrdDatapath.sv
module spiVrdDatapath
  import spiVrdPkg::*;
#(
  parameter logic [7:0] CTRL_OK = 8'h59
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              active,
  input  logic              sckRise,
  input  logic              sckFall,
  input  logic              siS,
  input  strobe_t           strb,
  input  logic [BYTE_W-1:0] regData,
  output logic              so,
  output logic              byteEnd,
  output logic [BYTE_W-1:0] rxByte,
  output logic              echoOk,
  output logic [BYTE_W-1:0] regAddr
);
  localparam logic [BYTE_W-1:0] CTRL_BAD = ~CTRL_OK;
  localparam int BIT_W = $clog2(BYTE_W);

  logic [BYTE_W-2:0] rxSh;
  logic [BIT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] txShift, pend, startAddr, rdPtr, prevTx, curTx, nextTx;
  logic              loadPend, rtMis, cntBad, echoErr;

  assign rxByte  = {rxSh, siS};
  assign byteEnd = active & sckRise & (bitCnt == BIT_W'(BYTE_W - 1));
  assign echoOk  = (rxByte == prevTx);
  assign regAddr = rdPtr;
  assign so      = active & txShift[BYTE_W-1];

  always_comb begin
    case (strb.txSel)
      TX_ADDR: nextTx = strb.capAddr ? rxByte : startAddr;
      TX_DATA: nextTx = (cntBad | strb.setCntBad) ? '0 : regData;
      TX_CTRL: nextTx = (cntBad | echoErr | strb.setCntBad | strb.setEchoErr)
                        ? CTRL_BAD : CTRL_OK;
      default: nextTx = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh <= '0; bitCnt <= '0; txShift <= '0; pend <= '0; loadPend <= 1'b0;
      rtMis <= 1'b0; startAddr <= '0; rdPtr <= '0; prevTx <= '0; curTx <= '0;
      cntBad <= 1'b0; echoErr <= 1'b0;
    end else if (!active) begin
      rxSh <= '0; bitCnt <= '0; txShift <= '0; pend <= '0; loadPend <= 1'b0;
      rtMis <= 1'b0; startAddr <= '0; rdPtr <= '0; prevTx <= '0; curTx <= '0;
      cntBad <= 1'b0; echoErr <= 1'b0;
    end else begin
      if (sckRise) begin
        rxSh   <= {rxSh[BYTE_W-3:0], siS};
        bitCnt <= bitCnt + 1'b1;
        rtMis  <= strb.ctrlPhase && (siS != txShift[BYTE_W-1]);
      end
      if (byteEnd) begin
        pend     <= nextTx;
        loadPend <= 1'b1;
        prevTx   <= curTx;
        curTx    <= nextTx;
        if (strb.capAddr) begin
          startAddr <= rxByte;
          rdPtr     <= rxByte;
        end
        if (strb.incPtr)     rdPtr   <= rdPtr + 1'b1;
        if (strb.setCntBad)  cntBad  <= 1'b1;
        if (strb.setEchoErr) echoErr <= 1'b1;
      end
      if (sckFall) begin
        rtMis <= 1'b0;
        if (loadPend) begin
          txShift  <= pend;
          loadPend <= 1'b0;
        end else if (rtMis) begin
          txShift <= CTRL_BAD << bitCnt;
        end else begin
          txShift <= {txShift[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spiVerifiedRead.sv
module spiVerifiedRead
  import spiVrdPkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] CTRL_OK     = 8'h59
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sck,
  input  logic       ncs,
  input  logic       si,
  output logic       so,
  output logic [7:0] regAddr,
  input  logic [7:0] regData
);
  logic              sckRise, sckFall, active, siS, byteEnd, echoOk;
  logic [BYTE_W-1:0] rxByte;
  strobe_t           strb;

  spiVrdSync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sckIn(sck), .ncsIn(ncs), .siIn(si),
    .sckRise(sckRise), .sckFall(sckFall), .active(active), .siS(siS)
  );

  spiVrdCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .active(active), .byteEnd(byteEnd),
    .rxByte(rxByte), .echoOk(echoOk), .strb(strb)
  );

  spiVrdDatapath #(.CTRL_OK(CTRL_OK)) u_dp (
    .clk(clk), .rstN(rstN), .active(active), .sckRise(sckRise),
    .sckFall(sckFall), .siS(siS), .strb(strb), .regData(regData),
    .so(so), .byteEnd(byteEnd), .rxByte(rxByte), .echoOk(echoOk),
    .regAddr(regAddr)
  );
endmodule

// File: rtl/spiVerifiedReadChk.sv
module spiVerifiedReadChk
  import spiVrdPkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       active,
  input logic       sckFall,
  input logic       byteEnd,
  input logic       so,
  input strobe_t    strb,
  input logic [7:0] rxByte,
  input logic [7:0] regAddr
);
  // R8
  idle_no_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> !byteEnd);

  // R9
  so_fall_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && !sckFall) |=> (!active || $stable(so)));

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteEnd && strb.incPtr) |=> (!active || regAddr == $past(regAddr) + 8'd1));

  // R1
  start_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteEnd && strb.capAddr) |=> (!active || regAddr == $past(rxByte)));
endmodule

bind spiVerifiedRead spiVerifiedReadChk u_chk (
  .clk(clk), .rstN(rstN), .active(active), .sckFall(sckFall),
  .byteEnd(byteEnd), .so(so), .strb(strb), .rxByte(rxByte), .regAddr(regAddr)
);

// File: tb/sim_spiVerifiedRead.sv
`timescale 1ns/1ps
module sim_spiVerifiedRead;
  localparam int HALF = 8;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0, rstN = 1'b0, sck = 1'b0, ncs = 1'b1, si = 1'b0;
  logic so;
  logic [7:0] regAddr, regData;
  logic [7:0] mem [256];

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];
  logic [7:0] gotQ[$];

  always #2.5 clk = ~clk;

  spiVerifiedRead u0 (
    .clk(clk), .rstN(rstN), .sck(sck), .ncs(ncs), .si(si), .so(so),
    .regAddr(regAddr), .regData(regData)
  );

  assign regData = mem[regAddr];

  task automatic check(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items as bytes are produced
  always @(negedge clk) begin
    while (gotQ.size() > 0 && expQ.size() > 0) begin
      automatic logic [7:0] g = gotQ.pop_front();
      automatic logic [7:0] e = expQ.pop_front();
      automatic string t = tagQ.pop_front();
      check(g === e, t, g, e);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected <%0d", cyc, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] e, input string t);
    expQ.push_back(e);
    tagQ.push_back(t);
  endtask

  // one byte, mode 0: SO sampled before the rise, again before the fall (R9)
  task automatic xfer(input logic [7:0] tx);
    logic [7:0] rxA, rxB;
    for (int b = 7; b >= 0; b--) begin
      si = tx[b];
      waitClk(HALF);
      rxA[b] = so;
      sck = 1'b1;
      waitClk(HALF);
      rxB[b] = so;
      sck = 1'b0;
    end
    check(rxA === rxB, "R9 SO moved on rising edge", rxB, rxA);
    gotQ.push_back(rxA);
  endtask

  function automatic logic [7:0] ctrlModel(input logic [7:0] base, input logic [7:0] m);
    logic [7:0] src = base;
    logic [7:0] r = '0;
    for (int b = 7; b >= 0; b--) begin
      r[b] = src[b];
      if (m[b] != src[b]) src = 8'hA6;
    end
    return r;
  endfunction

  // stopAt: 0 full read, 1 after data, 2 after address echo
  task automatic runRead(input logic [7:0] addr, input logic [7:0] cntByte,
                         input int corruptIdx, input int stopAt,
                         input logic [7:0] ctrlByte, input int extra);
    int n;
    logic bad, err;
    logic [7:0] dat [16];
    logic [7:0] echo;
    n   = int'(cntByte[7:4]) + 1;
    bad = (cntByte[3:0] != ~cntByte[7:4]);
    ncs = 1'b0;
    waitClk(HALF);
    push(8'h00, "R1 byte0");        xfer(addr);
    push(addr, "R1 address echo");  xfer(8'h00);
    if (stopAt != 2) begin
      push(8'h00, "R2 count byte");   xfer(cntByte);
      for (int k = 0; k < n; k++) begin
        dat[k] = bad ? 8'h00 : mem[8'(addr + k)];
        push(dat[k], bad ? "R6 zero data" : "R3 data");
        echo = 8'h00;
        if (k > 0) echo = dat[k-1] ^ ((corruptIdx == k-1) ? 8'h10 : 8'h00);
        xfer(echo);
      end
      if (stopAt == 0) begin
        echo = dat[n-1] ^ ((corruptIdx == n-1) ? 8'h10 : 8'h00);
        push(addr, "R4 tail address"); xfer(echo);
        err = bad || (corruptIdx >= 0);
        push(ctrlModel(err ? 8'hA6 : 8'h59, ctrlByte),
             (ctrlByte != 8'h59) ? "R7 realtime" : bad ? "R6 ctrl" : err ? "R5 ctrl" : "R4 ctrl");
        xfer(ctrlByte);
        for (int x = 0; x < extra; x++) begin
          push(8'h00, "R10 after ctrl"); xfer(8'h5A);
        end
      end
    end
    waitClk(HALF);
    ncs = 1'b1;
    waitClk(12);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    waitClk(4);
    rstN = 1'b1;
    waitClk(4);
    check(so === 1'b0, "R8 reset/idle SO", {7'd0, so}, 8'h00);

    runRead(8'h10, 8'h0F, -1, 0, 8'h59, 0);   // R2 single byte, R4 pass
    runRead(8'h20, 8'h3C, -1, 0, 8'h59, 2);   // R3 four bytes, R10 extra
    runRead(8'hFE, 8'h3C, -1, 0, 8'h59, 0);   // R3 wrap
    runRead(8'h40, 8'h2D, 1, 0, 8'h59, 0);    // R5 corrupted echo
    runRead(8'h50, 8'h35, -1, 0, 8'h59, 0);   // R6 bad count
    runRead(8'h60, 8'h1E, -1, 1, 8'h59, 0);   // R8 abort after data
    runRead(8'h70, 8'h0F, -1, 2, 8'h59, 0);   // R8 abort after echo
    runRead(8'h80, 8'h1E, -1, 0, 8'h59, 0);   // R8 clean read after aborts
    runRead(8'h90, 8'h0F, -1, 0, 8'h19, 0);   // R7 mismatch at bit 6 -> 0x66
    runRead(8'hA0, 8'h0F, 0, 0, 8'h59, 0);    // R7 on fail path
    runRead(8'hC0, 8'hF0, -1, 0, 8'h59, 1);   // R2 sixteen bytes
    check(so === 1'b0, "R8 idle SO after reads", {7'd0, so}, 8'h00);

    waitClk(10);
    check(expQ.size() == 0, "scoreboard drained", 8'(expQ.size()), 8'h00);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule